// File: doc/BRIEF.md
# LCD Frame Control Register

This block is the control and status register that sits between software and a segment LCD driver. Software reads and writes one 8-bit register that holds the driver enable, a low-power waveform select, a start-of-frame interrupt flag, an interrupt enable and a blanking request. A separate frame timer pulses a start-of-frame strobe. The block decides in which cycle each setting reaches the driver.

Switching the driver off acts at once. The waveform select and blanking requests are held until the next frame start, so the driver never changes mode in the middle of a frame. At each accepted frame start the block pulses a strobe that latches the display data. In the same cycle it raises the interrupt flag. In low-power waveform mode it raises the flag only on every second frame, counted from the moment the driver was enabled. The flag is cleared by writing a one to it or by an interrupt acknowledge. A flag set and a flag clear in the same cycle leave the flag set.

Top module: `lcd_frame_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `drv_en`, `lp_wave`, `blank`, `latch_strobe` and `irq` are all 0.
- R2: `rd_data` is {bit7 enable, bit6 waveform select, bit5 0, bit4 flag, bit3 interrupt enable, bit2 0, bit1 0, bit0 blanking}. A write with `wr_en` stores bits 7, 6, 3 and 0. Bits 5, 2 and 1 always read 0.
- R3: `drv_en` equals the stored enable bit and changes in the cycle after the write. A disable takes effect in that cycle even in the middle of a frame.
- R4: A `sof` pulse is ignored while the enable bit is 0: `latch_strobe` stays 0 and the flag is not set.
- R5: A `sof` pulse while enabled (and not disabled by a write in the same cycle) gives a one-cycle `latch_strobe` in the next cycle. In default waveform mode the flag reads 1 in that same cycle.
- R6: `lp_wave` takes the value of bit 6 only at an accepted frame start. A bit 6 change between frame starts does not reach `lp_wave`.
- R7: At an accepted frame start with bit 6 = 1, the flag is set only on even frames. Frames are counted from 0 at the first accepted frame after enable, and every accepted frame advances the count.
- R8: `blank` takes the value of bit 0 only at an accepted frame start, both when blanking is set and when it is cleared.
- R9: When the enable bit becomes 0, `lp_wave` and `blank` go to 0 in the same cycle as `drv_en`, and the frame count returns to even.
- R10: Writing 1 to bit 4 clears the flag, and writing 0 to bit 4 leaves it unchanged. A pulse on `irq_ack` also clears the flag.
- R11: When a flag set and a clear (by write or by acknowledge) fall in the same cycle, the flag reads 1 afterwards.
- R12: `irq` is registered. In the cycle after an edge it equals flag AND interrupt enable AND the `gie` value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| sof | input | 1 | Start-of-frame strobe from the frame timer |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| drv_en | output | 1 | Driver enable |
| lp_wave | output | 1 | Low-power waveform select toward the driver |
| blank | output | 1 | Blank command (drive all segment and common lines low) |
| latch_strobe | output | 1 | Frame data latch strobe |

## Verification
All 256 write values are swept, which separates the stored bits from the reserved bits. A directed sequence disables and re-enables the driver and then runs three frames in low-power mode. This tells a frame count that restarts on enable from one that runs freely, and a flag set on every frame from one set on every second frame. Mode and blanking changes are written between frame starts to show that they wait for the next frame. A long pseudo-random mix of writes, frame strobes, acknowledges and `gie` changes is compared against a model computed in the bench. It hits set-versus-clear collisions and disables that coincide with a frame strobe.

// File: rtl/lcdfc_pkg.sv
package lcdfc_pkg;
  parameter int REG_W    = 8;
  parameter int BIT_EN   = 7;
  parameter int BIT_LP   = 6;
  parameter int BIT_FLAG = 4;
  parameter int BIT_IE   = 3;
  parameter int BIT_BL   = 0;
  parameter int FLAG_DIV = 2;

  localparam logic [REG_W-1:0] WR_MASK =
    REG_W'((1 << BIT_EN) | (1 << BIT_LP) | (1 << BIT_IE) | (1 << BIT_BL));
endpackage

// File: rtl/lcdfc_regs.sv
module lcdfc_regs
  import lcdfc_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cur_vec,
  output logic         en_nxt,
  output logic         ie_nxt
);
  logic [W-1:0] nxt_vec;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (WR_MASK[i]) begin : g_rw
      assign nxt_vec[i] = wr_en ? wr_data[i] : cur_vec[i];
      always_ff @(posedge clk) begin
        if (rst) cur_vec[i] <= 1'b0;
        else     cur_vec[i] <= nxt_vec[i];
      end
    end else begin : g_rsv
      assign nxt_vec[i] = 1'b0;
      assign cur_vec[i] = 1'b0;
    end
  end

  assign en_nxt = nxt_vec[BIT_EN];
  assign ie_nxt = nxt_vec[BIT_IE];

  // R3: a disabling write clears the enable in the next cycle
  assert_disable_now_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[BIT_EN]) |=> !cur_vec[BIT_EN]);
endmodule

// File: rtl/lcdfc_frame.sv
module lcdfc_frame #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sof,
  input  logic en_cur,
  input  logic en_nxt,
  input  logic lp_cur,
  input  logic bl_cur,
  output logic lp_wave,
  output logic blank,
  output logic latch_strobe,
  output logic flag_set
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] phase;
  logic          accept;

  assign accept   = sof && en_cur && en_nxt;
  assign flag_set = accept && (!lp_cur || phase == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_wave      <= 1'b0;
      blank        <= 1'b0;
      latch_strobe <= 1'b0;
      phase        <= '0;
    end else begin
      latch_strobe <= accept;
      if (!en_nxt) begin
        lp_wave <= 1'b0;
        blank   <= 1'b0;
        phase   <= '0;
      end else if (accept) begin
        lp_wave <= lp_cur;
        blank   <= bl_cur;
        phase   <= (phase == CW'(DIV - 1)) ? '0 : phase + 1'b1;
      end
    end
  end

  // R5: a latch strobe always follows a frame strobe
  assert_strobe_after_sof_R5: assert property (@(posedge clk) disable iff (rst)
    latch_strobe |-> $past(sof));
  // R6: the waveform mode only rises at a frame boundary
  assert_lp_frame_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    $changed(lp_wave) |-> (latch_strobe || !lp_wave));
  // R8: blanking changes only at a frame boundary or on switch-off
  assert_blank_frame_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    $changed(blank) |-> (latch_strobe || !blank));
endmodule

// File: rtl/lcdfc_irq.sv
module lcdfc_irq (
  input  logic clk,
  input  logic rst,
  input  logic flag_set,
  input  logic flag_clr,
  input  logic ie_nxt,
  input  logic gie,
  output logic flag_q,
  output logic irq
);
  logic flag_nxt;

  always_comb begin
    if (flag_set)      flag_nxt = 1'b1;
    else if (flag_clr) flag_nxt = 1'b0;
    else               flag_nxt = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq    <= flag_nxt && ie_nxt && gie;
    end
  end

  // R11: a hardware set is never lost to a clear
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    flag_set |=> flag_q);
  // R12: no request without a pending flag
  assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag_q);
endmodule

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
  import lcdfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             sof,
  input  logic             irq_ack,
  input  logic             gie,
  output logic             irq,
  output logic             drv_en,
  output logic             lp_wave,
  output logic             blank,
  output logic             latch_strobe
);
  logic [REG_W-1:0] cur_vec;
  logic             en_nxt;
  logic             ie_nxt;
  logic             flag_set;
  logic             flag_clr;
  logic             flag_q;

  lcdfc_regs #(.W(REG_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cur_vec (cur_vec),
    .en_nxt  (en_nxt),
    .ie_nxt  (ie_nxt)
  );

  lcdfc_frame #(.DIV(FLAG_DIV)) u_frame (
    .clk          (clk),
    .rst          (rst),
    .sof          (sof),
    .en_cur       (cur_vec[BIT_EN]),
    .en_nxt       (en_nxt),
    .lp_cur       (cur_vec[BIT_LP]),
    .bl_cur       (cur_vec[BIT_BL]),
    .lp_wave      (lp_wave),
    .blank        (blank),
    .latch_strobe (latch_strobe),
    .flag_set     (flag_set)
  );

  assign flag_clr = (wr_en && wr_data[BIT_FLAG]) || irq_ack;

  lcdfc_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .flag_set (flag_set),
    .flag_clr (flag_clr),
    .ie_nxt   (ie_nxt),
    .gie      (gie),
    .flag_q   (flag_q),
    .irq      (irq)
  );

  assign drv_en  = cur_vec[BIT_EN];
  assign rd_data = cur_vec | (REG_W'(flag_q) << BIT_FLAG);

  // R9: nothing reaches the driver while it is off
  assert_off_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !drv_en |-> (!lp_wave && !blank && !latch_strobe));
  // R4: a frame strobe while disabled yields no latch
  assert_sof_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (sof && !drv_en) |=> !latch_strobe);
endmodule

// File: tb/lcd_frame_ctrl_test.sv
module lcd_frame_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, wr_en, sof, irq_ack, gie;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq, drv_en, lp_wave, blank, latch_strobe;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model state
  logic m_en, m_lp, m_ie, m_bl, m_flag, m_lpw, m_blank, m_latch, m_irq, m_par;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_frame_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sof(sof), .irq_ack(irq_ack), .gie(gie), .irq(irq), .drv_en(drv_en),
    .lp_wave(lp_wave), .blank(blank), .latch_strobe(latch_strobe)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read();
    return {m_en, m_lp, 1'b0, m_flag, m_ie, 2'b00, m_bl};
  endfunction

  task automatic compare_all();
    chk("R2", "rd_data", rd_data, m_read());
    chk("R3", "drv_en", 8'(drv_en), 8'(m_en));
    chk("R6", "lp_wave", 8'(lp_wave), 8'(m_lpw));
    chk("R8", "blank", 8'(blank), 8'(m_blank));
    chk("R5", "latch_strobe", 8'(latch_strobe), 8'(m_latch));
    chk("R12", "irq", 8'(irq), 8'(m_irq));
  endtask

  // drive at a falling edge, advance one rising edge, sample at the next falling edge
  task automatic step(input logic w, input logic [7:0] d, input logic s,
                      input logic a, input logic g, input logic cmp);
    logic en_n, lp_n, ie_n, bl_n, acc, setf, clr, flag_n;
    wr_en = w; wr_data = d; sof = s; irq_ack = a; gie = g;
    en_n = w ? d[7] : m_en;
    lp_n = w ? d[6] : m_lp;
    ie_n = w ? d[3] : m_ie;
    bl_n = w ? d[0] : m_bl;
    acc  = s && m_en && en_n;
    setf = acc && (!m_lp || !m_par);
    clr  = (w && d[4]) || a;
    flag_n = setf ? 1'b1 : (clr ? 1'b0 : m_flag);
    @(negedge clk);
    if (!en_n) begin
      m_lpw = 1'b0; m_blank = 1'b0; m_par = 1'b0;
    end else if (acc) begin
      m_lpw = m_lp; m_blank = m_bl; m_par = ~m_par;
    end
    m_latch = acc;
    m_irq   = flag_n && ie_n && g;
    m_en = en_n; m_lp = lp_n; m_ie = ie_n; m_bl = bl_n; m_flag = flag_n;
    wr_en = 1'b0; sof = 1'b0; irq_ack = 1'b0;
    if (cmp) compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; sof = 1'b0; irq_ack = 1'b0; gie = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    {m_en, m_lp, m_ie, m_bl, m_flag, m_lpw, m_blank, m_latch, m_irq, m_par} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    do_reset();
    // R1 reset state
    chk("R1", "rd_data", rd_data, 8'h00);
    chk("R1", "outputs", {3'b0, drv_en, lp_wave, blank, latch_strobe, irq}, 8'h00);

    // R4 frame strobe while disabled
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4", "latch_strobe", 8'(latch_strobe), 8'h00);
    chk("R4", "flag", 8'(rd_data[4]), 8'h00);

    // R2 sweep of every write value
    for (int v = 0; v < 256; v++) begin
      step(1'b1, 8'(v), 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R2", "reserved", rd_data & 8'h26, 8'h00);
    end

    // R5 / R12 normal mode frame
    step(1'b1, 8'h98, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5", "latch with flag", {6'b0, latch_strobe, rd_data[4]}, 8'h03);
    chk("R12", "irq", 8'(irq), 8'h01);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5", "strobe one cycle", 8'(latch_strobe), 8'h00);
    // R12 gie gates the request
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R12", "irq gated by gie", 8'(irq), 8'h00);
    // R10 writing zero keeps, writing one clears
    step(1'b1, 8'h88, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10", "write 0 keeps flag", 8'(rd_data[4]), 8'h01);
    step(1'b1, 8'h98, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10", "write 1 clears flag", 8'(rd_data[4]), 8'h00);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R10", "ack clears flag", 8'(rd_data[4]), 8'h00);
    // R11 set and clear together
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R11", "set wins over ack", 8'(rd_data[4]), 8'h01);
    step(1'b1, 8'h98, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R11", "set wins over write", 8'(rd_data[4]), 8'h01);

    // R6 mode change waits for frame start
    step(1'b1, 8'hD8, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6", "lp held mid-frame", 8'(lp_wave), 8'h00);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6", "lp at frame start", 8'(lp_wave), 8'h01);
    // R8 blanking waits for frame start
    step(1'b1, 8'hC9, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8", "blank held mid-frame", 8'(blank), 8'h00);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R8", "blank at frame start", 8'(blank), 8'h01);
    step(1'b1, 8'hC8, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8", "unblank held", 8'(blank), 8'h01);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R8", "unblank at frame start", 8'(blank), 8'h00);
    step(1'b1, 8'hC9, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);

    // R9 / R3 immediate disable clears driver outputs
    step(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R3", "disable immediate", 8'(drv_en), 8'h00);
    chk("R9", "outputs off", {6'b0, lp_wave, blank}, 8'h00);

    // R7 low-power frames counted from enable
    step(1'b1, 8'hD0, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R7", "frame 0 sets flag", 8'(rd_data[4]), 8'h01);
    step(1'b1, 8'hD0, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R7", "frame 1 no flag", 8'(rd_data[4]), 8'h00);
    chk("R7", "frame 1 still latches", 8'(latch_strobe), 8'h01);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R7", "frame 2 sets flag", 8'(rd_data[4]), 8'h01);

    // pseudo-random mix against the bench model
    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      logic w, s, a, g;
      logic [7:0] d;
      seed = seed * 32'd1103515245 + 32'd12345;
      w = (seed[17:16] == 2'b00);
      s = (seed[19:18] == 2'b00);
      a = (seed[22:20] == 3'b000);
      g = seed[23] | seed[24];
      d = seed[31:24] | {seed[25], 7'b0};
      step(w, d, s, a, g, 1'b1);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule